// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block serves eight auxiliary address pointers and one coefficient pointer, each 16 bits wide. An access request names a pointer and a step. The block returns the effective address one cycle later and updates the pointer after the access. Software does no bounds compare and takes no branch to keep a pointer inside a ring buffer.

Each pointer has its own mode bit. A pointer in linear mode is used directly as the address and moves by plus or minus one modulo 2^16. A pointer in circular mode is an offset. Its address is the base register bound to that pointer plus the offset, and the offset wraps inside a length register.

Base registers are shared by pointer pairs. Length registers are shared by groups of four pointers. A compatibility bit makes every auxiliary pointer use the first length register.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, all pointers, base registers, length registers and mode bits are zero, and `ea`, `ea_valid` and `wrap` are zero.
- R2: An accepted request (`req_valid` high with `req_ptr` at most 8) raises `ea_valid` for exactly the next cycle, and `ea` and `wrap` take that access's values in the same cycle. Without an accepted request, `ea_valid` is low, `wrap` is low and `ea` keeps its value.
- R3: A pointer whose mode bit is clear gives `ea` equal to the pointer. Its step is plus or minus one modulo 2^16: 0x0000 minus one is 0xFFFF and 0xFFFF plus one is 0x0000. `wrap` stays low.
- R4: A pointer whose mode bit is set gives `ea` = base + pointer modulo 2^16. Pointers 2k and 2k+1 (k = 0..3) use base register k, and pointer 8 uses base register 4.
- R5: In circular mode with a non-zero length L, an increment from an offset of L-1 or above sets the offset to 0. `wrap` is high with that access's address.
- R6: In circular mode with a non-zero length L, a decrement from offset 0 sets the offset to L-1. `wrap` is high with that access's address.
- R7: A length of 0 makes a circular pointer step like a linear one, with no wrap. The base is still added to the address.
- R8: Pointers 0-3 use length register 0, pointers 4-7 use length register 1, and pointer 8 uses length register 2.
- R9: When bit 15 of the mode word is set, pointers 0-7 all use length register 0, so length register 1 has no effect. Pointer 8 keeps length register 2.
- R10: Step codes are 2'b01 for +1 and 2'b11 for -1. Codes 2'b00 and 2'b10 leave the pointer unchanged and never raise `wrap`.
- R11: Writes use `wr_kind` 2'b00 for a pointer (index 0-8), 2'b01 for a base (index 0-4), 2'b10 for a length (index 0-2) and 2'b11 for the mode word. A pointer write in the same cycle as a request on that pointer wins over the post-modify. The access itself uses the old pointer value.
- R12: Bit i (i = 0..8) of the mode word selects circular mode for pointer i only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Write target class |
| wr_idx | input | 4 | Register index within the class |
| wr_data | input | 16 | Write data |
| req_valid | input | 1 | Access request |
| req_ptr | input | 4 | Pointer select, 0-7 auxiliary, 8 coefficient |
| req_step | input | 2 | Post-modify step code |
| ea | output | 16 | Registered effective address |
| ea_valid | output | 1 | `ea` carries a new access this cycle |
| wrap | output | 1 | The access wrapped its offset |

## Verification
The assertions assume that `req_ptr` and `req_step` are steady and defined during each cycle that `req_valid` is high. They also assume that a circular pointer's offset starts inside its buffer whenever the exact wrap point matters. The bench drives all inputs at the falling edge and loads every pointer with a known value before it uses the pointer. Only one test loads an offset above L-1 on purpose, to exercise the clamp in R5. Register writes never share a cycle with a request, except in the one collision test that R11 defines.

// File: rtl/circ_addr_pkg.sv
// Package: shared step and write-class codes for the circular address generator.
// Assumes: callers drive 2-bit codes on plain ports and cast them here.
package circ_addr_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_INC  = 2'b01,
        STEP_RSV  = 2'b10,
        STEP_DEC  = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        WK_PTR  = 2'b00,
        WK_BASE = 2'b01,
        WK_LEN  = 2'b10,
        WK_MODE = 2'b11
    } wr_kind_e;
endpackage

// File: rtl/cag_cfg_regs.sv
// Module: base, length and mode registers of the address generator.
// Assumes: out-of-range indices are ignored; the compatibility flag sits in the top bit of the mode word.
module cag_cfg_regs
    import circ_addr_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_PTR  = 9,
    parameter int NUM_BASE = 5,
    parameter int NUM_LEN  = 3,
    parameter int IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base_q [NUM_BASE],
    output logic [ADDR_W-1:0] len_q  [NUM_LEN],
    output logic [NUM_PTR-1:0] circ_q,
    output logic              compat_q
);
    for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
        // Load one base register when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[b] <= '0;
            end else if (wr_en && wr_kind == WK_BASE && wr_idx == IDX_W'(b)) begin
                base_q[b] <= wr_data;
            end
        end
    end

    for (genvar l = 0; l < NUM_LEN; l++) begin : g_len
        // Load one length register when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_q[l] <= '0;
            end else if (wr_en && wr_kind == WK_LEN && wr_idx == IDX_W'(l)) begin
                len_q[l] <= wr_data;
            end
        end
    end

    // Capture the per-pointer circular bits and the compatibility flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            circ_q   <= '0;
            compat_q <= 1'b0;
        end else if (wr_en && wr_kind == WK_MODE) begin
            circ_q   <= wr_data[NUM_PTR-1:0];
            compat_q <= wr_data[ADDR_W-1];
        end
    end
endmodule

// File: rtl/cag_ptr_file.sv
// Module: pointer register file with a write port and a post-modify port.
// Assumes: a software write to a pointer overrides a post-modify of that pointer in the same cycle.
module cag_ptr_file
    import circ_addr_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_PTR = 9,
    parameter int IDX_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [ADDR_W-1:0] upd_val,
    output logic [ADDR_W-1:0] ptr_q [NUM_PTR]
);
    for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
        logic hit_wr;
        logic hit_upd;
        assign hit_wr  = wr_en && wr_kind == WK_PTR && wr_idx == IDX_W'(p);
        assign hit_upd = upd_en && upd_idx == IDX_W'(p);

        // Update one pointer, with the software write taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[p] <= '0;
            end else if (hit_wr) begin
                ptr_q[p] <= wr_data;
            end else if (hit_upd) begin
                ptr_q[p] <= upd_val;
            end
        end
    end
endmodule

// File: rtl/cag_step.sv
// Module: combinational next-offset logic with modulo wrap.
// Assumes: a length of zero or linear mode means plain 2^16 arithmetic with no wrap.
module cag_step
    import circ_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [1:0]        step,
    input  logic              circ,
    input  logic [ADDR_W-1:0] len,
    output logic [ADDR_W-1:0] nxt,
    output logic              wrapped
);
    logic              ring;
    logic [ADDR_W-1:0] last;

    assign ring = circ && (len != '0);
    assign last = len - ADDR_W'(1);

    // Choose the post-modified offset and flag a wrap.
    always_comb begin
        nxt     = cur;
        wrapped = 1'b0;
        unique case (step_e'(step))
            STEP_INC: begin
                if (ring && cur >= last) begin
                    nxt     = '0;
                    wrapped = 1'b1;
                end else begin
                    nxt = cur + ADDR_W'(1);
                end
            end
            STEP_DEC: begin
                if (ring && cur == '0) begin
                    nxt     = last;
                    wrapped = 1'b1;
                end else begin
                    nxt = cur - ADDR_W'(1);
                end
            end
            default: begin
                nxt     = cur;
                wrapped = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/circ_addr_gen.sv
// Module: top of the circular address generator.
// Does: picks the pointer, its base and its length, forms the effective address,
//       registers it with one cycle of latency and writes back the post-modified pointer.
// Assumes: N_AUX is a multiple of 4; the coefficient pointer has index N_AUX.
module circ_addr_gen
    import circ_addr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int N_AUX  = 8,
    localparam int NUM_PTR  = N_AUX + 1,
    localparam int NUM_BASE = N_AUX / 2 + 1,
    localparam int NUM_LEN  = N_AUX / 4 + 1,
    localparam int IDX_W    = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_ptr,
    input  logic [1:0]        req_step,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid,
    output logic              wrap
);
    localparam int BASE_IW = (NUM_BASE > 1) ? $clog2(NUM_BASE) : 1;
    localparam int LEN_IW  = (NUM_LEN > 1) ? $clog2(NUM_LEN) : 1;

    logic [ADDR_W-1:0]  base_q [NUM_BASE];
    logic [ADDR_W-1:0]  len_q  [NUM_LEN];
    logic [ADDR_W-1:0]  ptr_q  [NUM_PTR];
    logic [NUM_PTR-1:0] circ_q;
    logic               compat_q;

    logic               req_accept;
    logic [IDX_W-1:0]   pidx;
    logic               is_coef;
    logic [BASE_IW-1:0] base_idx;
    logic [LEN_IW-1:0]  len_idx;
    logic [ADDR_W-1:0]  cur_ptr;
    logic [ADDR_W-1:0]  sel_base;
    logic [ADDR_W-1:0]  sel_size;
    logic               sel_circ;
    logic [ADDR_W-1:0]  next_ptr;
    logic               step_wrap;
    logic [ADDR_W-1:0]  ea_d;

    cag_cfg_regs #(
        .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .NUM_BASE(NUM_BASE),
        .NUM_LEN(NUM_LEN), .IDX_W(IDX_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .base_q(base_q), .len_q(len_q),
        .circ_q(circ_q), .compat_q(compat_q)
    );

    // Accept only requests that name an existing pointer.
    assign req_accept = req_valid && (req_ptr < IDX_W'(NUM_PTR));
    assign pidx       = req_accept ? req_ptr : '0;
    assign is_coef    = (pidx == IDX_W'(N_AUX));

    // Map the pointer index to its base and length registers.
    always_comb begin
        if (is_coef) begin
            base_idx = BASE_IW'(NUM_BASE - 1);
            len_idx  = LEN_IW'(NUM_LEN - 1);
        end else begin
            base_idx = BASE_IW'(pidx >> 1);
            len_idx  = compat_q ? '0 : LEN_IW'(pidx >> 2);
        end
    end

    assign cur_ptr  = ptr_q[pidx];
    assign sel_base = base_q[base_idx];
    assign sel_size = len_q[len_idx];
    assign sel_circ = circ_q[pidx];
    assign ea_d     = sel_circ ? (sel_base + cur_ptr) : cur_ptr;

    cag_step #(.ADDR_W(ADDR_W)) step_i (
        .cur(cur_ptr), .step(req_step), .circ(sel_circ), .len(sel_size),
        .nxt(next_ptr), .wrapped(step_wrap)
    );

    cag_ptr_file #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .IDX_W(IDX_W)) ptrs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .upd_en(req_accept),
        .upd_idx(pidx), .upd_val(next_ptr), .ptr_q(ptr_q)
    );

    // Register the effective address and the wrap flag for one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea       <= '0;
            ea_valid <= 1'b0;
            wrap     <= 1'b0;
        end else begin
            ea_valid <= req_accept;
            wrap     <= req_accept && step_wrap;
            if (req_accept) begin
                ea <= ea_d;
            end
        end
    end
endmodule

// File: rtl/circ_addr_gen_chk.sv
// Module: property checker bound to circ_addr_gen.
// Assumes: the request inputs are defined whenever reset is released.
module circ_addr_gen_chk #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    parameter int NUM_PTR = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [IDX_W-1:0]  req_ptr,
    input logic [1:0]        req_step,
    input logic [ADDR_W-1:0] ea,
    input logic              ea_valid,
    input logic              wrap,
    input logic [ADDR_W-1:0] cur_ptr,
    input logic [ADDR_W-1:0] sel_size,
    input logic              sel_circ
);
    logic acc;
    assign acc = req_valid && (req_ptr < IDX_W'(NUM_PTR));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ea_valid);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (!ea_valid && !wrap && $stable(ea)));
    p_linear_ea_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !sel_circ) |=> (ea == $past(cur_ptr) && !wrap));
    p_inc_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sel_circ && sel_size != '0 && req_step == 2'b01 &&
         cur_ptr >= sel_size - ADDR_W'(1)) |=> wrap);
    p_dec_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sel_circ && sel_size != '0 && req_step == 2'b11 &&
         cur_ptr == '0) |=> wrap);
    p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sel_size == '0) |=> !wrap);
    p_hold_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_step[0]) |=> !wrap);
    p_wrap_has_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> ea_valid);
endmodule

bind circ_addr_gen circ_addr_gen_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_PTR(NUM_PTR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ptr(req_ptr),
    .req_step(req_step), .ea(ea), .ea_valid(ea_valid), .wrap(wrap),
    .cur_ptr(cur_ptr), .sel_size(sel_size), .sel_circ(sel_circ)
);

// File: tb/circ_addr_gen_tb_top.sv
// Directed bench for circ_addr_gen: one task per scenario, each checking its own results.
module circ_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_kind;
    logic [3:0]  wr_idx;
    logic [15:0] wr_data;
    logic        req_valid;
    logic [3:0]  req_ptr;
    logic [1:0]  req_step;
    logic [15:0] ea;
    logic        ea_valid;
    logic        wrap;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    localparam logic [1:0] K_PTR = 2'b00, K_BASE = 2'b01, K_LEN = 2'b10, K_MODE = 2'b11;
    localparam logic [1:0] S_HOLD = 2'b00, S_INC = 2'b01, S_RSV = 2'b10, S_DEC = 2'b11;

    always #2 clk = ~clk;

    circ_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .req_valid(req_valid),
        .req_ptr(req_ptr), .req_step(req_step), .ea(ea),
        .ea_valid(ea_valid), .wrap(wrap)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input int idx, input logic [15:0] d);
        wr_en = 1'b1; wr_kind = k; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic access(input string tag, input int p, input logic [1:0] s,
                          input logic [15:0] exp_ea, input logic exp_wrap);
        req_valid = 1'b1; req_ptr = 4'(p); req_step = s;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(ea_valid), 32'd1);
        check({tag, " ea"}, 32'(ea), 32'(exp_ea));
        check({tag, " wrap"}, 32'(wrap), 32'(exp_wrap));
    endtask

    task automatic t_reset();
        check("R1 ea", 32'(ea), 32'd0);
        check("R1 ea_valid", 32'(ea_valid), 32'd0);
        check("R1 wrap", 32'(wrap), 32'd0);
        access("R1 ptr4 zero", 4, S_HOLD, 16'h0000, 1'b0);
        access("R1 coef zero", 8, S_HOLD, 16'h0000, 1'b0);
    endtask

    task automatic t_linear();
        wr(K_MODE, 0, 16'h0000);
        wr(K_PTR, 2, 16'h0010);
        access("R3 inc", 2, S_INC, 16'h0010, 1'b0);
        access("R3 after inc", 2, S_HOLD, 16'h0011, 1'b0);
        access("R10 reserved step", 2, S_RSV, 16'h0011, 1'b0);
        access("R10 after reserved", 2, S_HOLD, 16'h0011, 1'b0);
        @(negedge clk);
        check("R2 idle valid", 32'(ea_valid), 32'd0);
        check("R2 idle ea hold", 32'(ea), 32'h0011);
        wr(K_PTR, 3, 16'h0000);
        access("R3 dec from 0", 3, S_DEC, 16'h0000, 1'b0);
        access("R3 modulo low", 3, S_INC, 16'hFFFF, 1'b0);
        access("R3 modulo high", 3, S_HOLD, 16'h0000, 1'b0);
    endtask

    task automatic t_circ_inc();
        wr(K_BASE, 1, 16'h1000);
        wr(K_LEN, 0, 16'd4);
        wr(K_MODE, 0, 16'h0004);
        wr(K_PTR, 2, 16'h0002);
        access("R4 base add", 2, S_INC, 16'h1002, 1'b0);
        access("R5 inc at end", 2, S_INC, 16'h1003, 1'b1);
        access("R5 back to start", 2, S_HOLD, 16'h1000, 1'b0);
        wr(K_PTR, 2, 16'h0007);
        access("R5 beyond end", 2, S_INC, 16'h1007, 1'b1);
        access("R5 clamped to 0", 2, S_HOLD, 16'h1000, 1'b0);
        access("R12 neighbour linear", 3, S_HOLD, 16'h0000, 1'b0);
    endtask

    task automatic t_circ_dec();
        access("R6 dec at 0", 2, S_DEC, 16'h1000, 1'b1);
        access("R6 to len-1", 2, S_HOLD, 16'h1003, 1'b0);
        access("R6 plain dec", 2, S_DEC, 16'h1003, 1'b0);
        access("R6 after dec", 2, S_HOLD, 16'h1002, 1'b0);
    endtask

    task automatic t_groups();
        wr(K_BASE, 2, 16'h3000);
        wr(K_LEN, 1, 16'd2);
        wr(K_MODE, 0, 16'h0020);
        wr(K_PTR, 5, 16'h0001);
        access("R8 ptr5 uses len1", 5, S_INC, 16'h3001, 1'b1);
        access("R8 ptr5 wrapped", 5, S_HOLD, 16'h3000, 1'b0);
        wr(K_BASE, 4, 16'h2000);
        wr(K_LEN, 2, 16'd3);
        wr(K_MODE, 0, 16'h0100);
        wr(K_PTR, 8, 16'h0002);
        access("R4 coef base4 R8 len2", 8, S_INC, 16'h2002, 1'b1);
        access("R8 coef wrapped", 8, S_HOLD, 16'h2000, 1'b0);
    endtask

    task automatic t_compat();
        wr(K_MODE, 0, 16'h8020);
        wr(K_PTR, 5, 16'h0001);
        access("R9 ptr5 no wrap at 1", 5, S_INC, 16'h3001, 1'b0);
        access("R9 ptr5 step", 5, S_INC, 16'h3002, 1'b0);
        access("R9 ptr5 wrap at 3", 5, S_INC, 16'h3003, 1'b1);
        access("R9 ptr5 wrapped", 5, S_HOLD, 16'h3000, 1'b0);
        wr(K_MODE, 0, 16'h8100);
        wr(K_PTR, 8, 16'h0002);
        access("R9 coef keeps len2", 8, S_INC, 16'h2002, 1'b1);
    endtask

    task automatic t_zero_len();
        wr(K_LEN, 0, 16'd0);
        wr(K_BASE, 0, 16'h0100);
        wr(K_MODE, 0, 16'h0001);
        wr(K_PTR, 0, 16'hFFFF);
        access("R7 modulo base add", 0, S_INC, 16'h00FF, 1'b0);
        access("R7 linear step", 0, S_HOLD, 16'h0100, 1'b0);
        access("R7 dec no wrap", 0, S_DEC, 16'h0100, 1'b0);
        access("R7 after dec", 0, S_HOLD, 16'h00FF, 1'b0);
    endtask

    task automatic t_collision();
        wr(K_MODE, 0, 16'h0000);
        wr(K_PTR, 1, 16'h0005);
        wr_en = 1'b1; wr_kind = K_PTR; wr_idx = 4'd1; wr_data = 16'h0040;
        req_valid = 1'b1; req_ptr = 4'd1; req_step = S_INC;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R11 access uses old", 32'(ea), 32'h0005);
        access("R11 write wins", 1, S_HOLD, 16'h0040, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_kind = '0; wr_idx = '0; wr_data = '0;
        req_valid = 1'b0; req_ptr = '0; req_step = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_circ_inc();
        t_circ_dec();
        t_groups();
        t_compat();
        t_zero_len();
        t_collision();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule